// File: doc/BRIEF.md
# T-Tiled Framebuffer Address Generator

This block maps pixel coordinates of a 32-bit-per-pixel image to byte offsets from the start of the image buffer. The tiled layout nests three levels: 4x4-pixel micro-tiles of 64 bytes, 16x16-pixel subtiles of 1 KB, and 32x32-pixel tiles of 4 KB. Tile rows run in a serpentine order, and the order of the subtiles inside a tile depends on whether the tile row is even or odd. A second layout is a plain linear one with a programmable pitch in bytes.

There are two ways to use the block. In random-access mode, each coordinate pair accepted on a valid/ready handshake returns one offset on a registered output. In scan mode, a single start pulse makes the block walk the whole image in raster order and emit one offset per cycle under output backpressure. The final pixel is flagged. Coordinates outside the programmed image raise an error flag, and the offset reported with them is zero.

Top module: `tiled_addr_gen`

## Requirements
- R1: After reset, `out_valid` is 0 and `req_ready` is 1.
- R2: With `cfg_tiled`=1, bits [11:0] of the offset are {slot[1:0], y[3:2], x[3:2], y[1:0], x[1:0], 2'b00}. Micro-tiles inside a subtile and pixels inside a micro-tile are in raster order, and y counts upward from the lowest address.
- R3: The subtile slot is set by sub_x = x[4] and sub_y = y[4]. In even tile rows the slots 0..3 hold (sub_x,sub_y) = (0,0),(0,1),(1,1),(1,0). In odd tile rows they hold (1,1),(1,0),(0,0),(0,1).
- R4: With `cfg_tiled`=1, offset[OW-1:12] = tile_row*T + p. Here tile_row = y>>5, T = (width+31)>>5, and p = x>>5 in even tile rows or T-1-(x>>5) in odd tile rows.
- R5: With `cfg_tiled`=0, the offset is y*`cfg_pitch` + 4*x.
- R6: If x >= width or y >= height, `out_err` is 1 and `out_offset` is 0. Otherwise `out_err` is 0.
- R7: `req_ready` is 1 when no scan is running, `scan_start` is low, and the output register is empty or being taken. An accepted request appears on the output one clock later.
- R8: After `scan_start`, the outputs carry every pixel once in raster order (x fastest, y from 0). Each `out_ready` cycle moves on to the next pixel. `out_last` is 1 only with pixel (width-1, height-1).
- R9: While `out_valid`=1 and `out_ready`=0, the offset, error and last outputs and the scan position keep their values.
- R10: While a scan runs, `req_ready` is 0. A `scan_start` with width or height of zero starts nothing.
- R11: Once the last scan offset is taken, the block returns to random-access mode with an empty output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tiled | input | 1 | 1 selects tiled layout, 0 selects linear |
| cfg_width | input | CW | Image width in pixels |
| cfg_height | input | CW | Image height in pixels |
| cfg_pitch | input | 16 | Linear row pitch in bytes |
| scan_start | input | 1 | Pulse to begin a raster walk |
| req_valid | input | 1 | Random-access coordinate valid |
| req_ready | output | 1 | Random-access coordinate accepted |
| req_x | input | CW | Requested column |
| req_y | input | CW | Requested row |
| out_valid | output | 1 | Offset valid |
| out_ready | input | 1 | Consumer takes the offset |
| out_offset | output | OW | Byte offset from buffer base |
| out_last | output | 1 | Final pixel of a scan |
| out_err | output | 1 | Coordinate outside the image |

## Verification
The hardest conditions to reach are the odd tile rows combined with a partial last tile column, where the reversed tile direction and the swapped subtile order act together. The stimulus uses a 40x70 image, which has two tiles per row (one of them partial) and three tile rows. A full sweep of random-access coordinates, extending a few pixels past both edges, covers every subtile slot in both row parities. A scan under an irregular ready pattern then checks each offset against an arithmetic model while the output is held stalled.

// File: rtl/tta_pkg.sv
package tta_pkg;
    localparam int TILE_LOG   = 12; // 4 KB tile
    localparam int TILE_PX    = 5;  // 32 pixels per tile edge
    localparam int SUB_PX     = 4;  // 16 pixels per subtile edge
    localparam int PITCH_W    = 16;
    localparam int BPP_LOG    = 2;  // 4 bytes per pixel
endpackage

// File: rtl/tta_slot_map.sv
module tta_slot_map (
    input  logic       sub_x,
    input  logic       sub_y,
    input  logic       odd_row,
    output logic [1:0] slot
);
    // even: (0,0)->0 (0,1)->1 (1,1)->2 (1,0)->3 ; odd rows flip the upper slot bit
    always_comb begin
        slot = {sub_x ^ odd_row, sub_x ^ sub_y};
    end
endmodule

// File: rtl/tta_offset_calc.sv
module tta_offset_calc #(
    parameter int CW = 12,
    parameter int OW = 32
) (
    input  logic                      tiled,
    input  logic [CW-1:0]             width,
    input  logic [CW-1:0]             height,
    input  logic [tta_pkg::PITCH_W-1:0] pitch,
    input  logic [CW-1:0]             x,
    input  logic [CW-1:0]             y,
    output logic [OW-1:0]             offset,
    output logic                      err
);
    import tta_pkg::*;

    localparam int RW = CW - TILE_PX;     // tile row/col index width
    localparam int TW = CW - TILE_PX + 1; // tiles-per-row width

    logic [CW:0]     width_rnd;
    logic [TW-1:0]   tiles_per_row;
    logic [RW-1:0]   tile_row;
    logic [RW-1:0]   tile_col;
    logic [TW-1:0]   tile_pos;
    logic [1:0]      slot;
    logic [OW-1:0]   tile_idx;
    logic [OW-1:0]   tiled_off;
    logic [OW-1:0]   lin_off;
    logic [TILE_LOG-1:0] in_tile;

    tta_slot_map u_slot (
        .sub_x   (x[SUB_PX]),
        .sub_y   (y[SUB_PX]),
        .odd_row (y[TILE_PX]),
        .slot    (slot)
    );

    always_comb begin
        width_rnd     = {1'b0, width} + (CW+1)'(31);
        tiles_per_row = width_rnd[CW:TILE_PX];
        tile_row      = y[CW-1:TILE_PX];
        tile_col      = x[CW-1:TILE_PX];
        if (y[TILE_PX]) begin
            tile_pos = tiles_per_row - TW'(1) - TW'(tile_col);
        end else begin
            tile_pos = TW'(tile_col);
        end
        tile_idx  = OW'(tile_row) * OW'(tiles_per_row) + OW'(tile_pos);
        in_tile   = {slot, y[3:2], x[3:2], y[1:0], x[1:0], 2'b00};
        tiled_off = (tile_idx << TILE_LOG) | OW'(in_tile);
        lin_off   = OW'(y) * OW'(pitch) + (OW'(x) << BPP_LOG);
        err       = (x >= width) || (y >= height);
        if (err) begin
            offset = '0;
        end else if (tiled) begin
            offset = tiled_off;
        end else begin
            offset = lin_off;
        end
    end
endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen #(
    parameter int CW = 12,
    parameter int OW = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_tiled,
    input  logic [CW-1:0]               cfg_width,
    input  logic [CW-1:0]               cfg_height,
    input  logic [tta_pkg::PITCH_W-1:0] cfg_pitch,
    input  logic                        scan_start,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [CW-1:0]               req_x,
    input  logic [CW-1:0]               req_y,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [OW-1:0]               out_offset,
    output logic                        out_last,
    output logic                        out_err
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cx;
        logic [CW-1:0] cy;
        logic          vld;
        logic [OW-1:0] off;
        logic          last;
        logic          err;
    } state_t;

    state_t st_d, st_q;

    logic          load;
    logic [CW-1:0] calc_x;
    logic [CW-1:0] calc_y;
    logic [OW-1:0] calc_off;
    logic          calc_err;
    logic          end_col;
    logic          end_img;
    logic          scan_busy;

    tta_offset_calc #(.CW(CW), .OW(OW)) u_calc (
        .tiled  (cfg_tiled),
        .width  (cfg_width),
        .height (cfg_height),
        .pitch  (cfg_pitch),
        .x      (calc_x),
        .y      (calc_y),
        .offset (calc_off),
        .err    (calc_err)
    );

    always_comb begin
        st_d      = st_q;
        load      = !st_q.vld || out_ready;
        req_ready = load && !st_q.busy && !scan_start;
        calc_x    = st_q.busy ? st_q.cx : req_x;
        calc_y    = st_q.busy ? st_q.cy : req_y;
        end_col   = (st_q.cx == cfg_width - CW'(1));
        end_img   = end_col && (st_q.cy == cfg_height - CW'(1));
        if (load) begin
            st_d.vld  = 1'b0;
            st_d.last = 1'b0;
        end
        if (!st_q.busy) begin
            if (scan_start) begin
                if (cfg_width != '0 && cfg_height != '0) begin
                    st_d.busy = 1'b1;
                    st_d.cx   = '0;
                    st_d.cy   = '0;
                end
            end else if (req_valid && req_ready) begin
                st_d.vld  = 1'b1;
                st_d.off  = calc_off;
                st_d.err  = calc_err;
                st_d.last = 1'b0;
            end
        end else if (load) begin
            st_d.vld  = 1'b1;
            st_d.off  = calc_off;
            st_d.err  = calc_err;
            st_d.last = end_img;
            if (end_img) begin
                st_d.busy = 1'b0;
            end
            if (end_col) begin
                st_d.cx = '0;
                st_d.cy = st_q.cy + CW'(1);
            end else begin
                st_d.cx = st_q.cx + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_offset = st_q.off;
    assign out_last   = st_q.last;
    assign out_err    = st_q.err;
    assign scan_busy  = st_q.busy;
endmodule

// File: rtl/tiled_addr_gen_chk.sv
module tiled_addr_gen_chk #(
    parameter int CW = 12,
    parameter int OW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [OW-1:0] out_offset,
    input logic          out_last,
    input logic          out_err,
    input logic          scan_busy
);
    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_offset) && $stable(out_err) && $stable(out_last));

    // R6
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> out_offset == '0);

    // R10
    busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |-> !req_ready);

    // R8
    last_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> !out_err);

    // R7
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> out_valid);

    // R11
    last_ends_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last && out_ready |=> !scan_busy);
endmodule

bind tiled_addr_gen tiled_addr_gen_chk #(.CW(CW), .OW(OW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_offset (out_offset),
    .out_last   (out_last),
    .out_err    (out_err),
    .scan_busy  (scan_busy)
);

// File: tb/tiled_addr_gen_tb.sv
module tiled_addr_gen_tb;
    localparam int CW = 12;
    localparam int OW = 32;
    localparam int W  = 40;
    localparam int H  = 70;
    localparam int P  = 176;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_tiled = 1'b1;
    logic [CW-1:0] cfg_width = CW'(W);
    logic [CW-1:0] cfg_height = CW'(H);
    logic [15:0]   cfg_pitch = 16'(P);
    logic          scan_start = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [CW-1:0] req_x = '0;
    logic [CW-1:0] req_y = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [OW-1:0] out_offset;
    logic          out_last;
    logic          out_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tiled_addr_gen #(.CW(CW), .OW(OW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_tiled(cfg_tiled), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .cfg_pitch(cfg_pitch), .scan_start(scan_start),
        .req_valid(req_valid), .req_ready(req_ready), .req_x(req_x), .req_y(req_y),
        .out_valid(out_valid), .out_ready(out_ready), .out_offset(out_offset),
        .out_last(out_last), .out_err(out_err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference tiled offset built from the subtile position names
    function automatic longint ref_tiled(int x, int y, int w);
        int tpr, tr, tc, col, qx, qy, slot, micro, pix;
        tpr = (w + 31) / 32;
        tr  = y / 32;
        tc  = x / 32;
        col = (tr % 2 == 1) ? (tpr - 1 - tc) : tc;
        qx  = (x / 16) % 2;
        qy  = (y / 16) % 2;
        // positions: 0=BL 1=TL 2=TR 3=BR
        if (tr % 2 == 0) begin
            if (qx == 0 && qy == 0) slot = 0;
            else if (qx == 0) slot = 1;
            else if (qy == 1) slot = 2;
            else slot = 3;
        end else begin
            if (qx == 1 && qy == 1) slot = 0;
            else if (qx == 1) slot = 1;
            else if (qy == 0) slot = 2;
            else slot = 3;
        end
        micro = ((y % 16) / 4) * 4 + (x % 16) / 4;
        pix   = (y % 4) * 4 + (x % 4);
        return longint'(tr * tpr + col) * 4096 + slot * 1024 + micro * 64 + pix * 4;
    endfunction

    function automatic longint ref_off(bit tiled, int x, int y, bit oob);
        if (oob) return 0;
        if (tiled) return ref_tiled(x, y, W);
        return longint'(y) * P + x * 4;
    endfunction

    task automatic sweep(input bit tiled, input int xmax, input int ymax);
        longint exp_off;
        bit     exp_err;
        bit     have;
        have = 0;
        cfg_tiled = tiled;
        out_ready = 1'b1;
        for (int y = 0; y <= ymax; y++) begin
            for (int x = 0; x <= xmax; x++) begin
                if (have) begin
                    chk(out_valid == 1'b1, "R7 valid", longint'(out_valid), 1);
                    chk(out_err == exp_err, "R6 err", longint'(out_err), longint'(exp_err));
                    chk(longint'(out_offset) == exp_off,
                        exp_err ? "R6 offset" : (tiled ? "R2/R3/R4 offset" : "R5 offset"),
                        longint'(out_offset), exp_off);
                end
                exp_err = (x >= W) || (y >= H);
                exp_off = ref_off(tiled, x, y, exp_err);
                have = 1;
                req_valid = 1'b1;
                req_x = CW'(x);
                req_y = CW'(y);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        chk(out_valid == 1'b1, "R7 final valid", longint'(out_valid), 1);
        chk(longint'(out_offset) == exp_off, "R2 final offset", longint'(out_offset), exp_off);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 drains", longint'(out_valid), 0);
    endtask

    task automatic scan(input bit tiled);
        int  idx, cyc, n;
        bit  done, rdy;
        longint exp_off;
        n = W * H;
        idx = 0; cyc = 0; done = 0;
        cfg_tiled = tiled;
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        while (!done) begin
            if (cyc == 5) chk(req_ready == 1'b0, "R10 busy", longint'(req_ready), 0);
            rdy = (cyc % 3) != 2;
            if (out_valid) begin
                exp_off = ref_off(tiled, idx % W, idx / W, 0);
                chk(longint'(out_offset) == exp_off, "R8/R9 scan offset", longint'(out_offset), exp_off);
                chk(out_last == (idx == n - 1), "R8 last", longint'(out_last), longint'(idx == n - 1));
                if (rdy) begin
                    if (idx == n - 1) done = 1;
                    idx++;
                end
            end
            out_ready = rdy;
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b1;
        chk(out_valid == 1'b0, "R11 empty", longint'(out_valid), 0);
        chk(req_ready == 1'b1, "R11 ready", longint'(req_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
        chk(req_ready == 1'b1, "R1 req_ready", longint'(req_ready), 1);

        // R2 R3 R4 R6 R7: tiled sweep past both edges
        sweep(1'b1, W + 3, H + 3);
        // R5: linear sweep
        sweep(1'b0, W + 1, H + 1);

        // R8 R9 R10 R11: scans under irregular backpressure
        scan(1'b1);
        scan(1'b0);

        // R11: random access works after scan
        cfg_tiled = 1'b1;
        req_valid = 1'b1; req_x = CW'(33); req_y = CW'(40);
        @(negedge clk);
        req_valid = 1'b0;
        chk(longint'(out_offset) == ref_tiled(33, 40, W), "R11 after scan",
            longint'(out_offset), ref_tiled(33, 40, W));

        // R10: zero-width start ignored
        @(negedge clk);
        cfg_width = '0;
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 zero width valid", longint'(out_valid), 0);
        chk(req_ready == 1'b1, "R10 zero width ready", longint'(req_ready), 1);
        cfg_width = CW'(W);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule